// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block is the read-after-write hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It decides, for each ALU operand of the instruction now in execute, whether the operand comes from the register file or is taken early from a newer result that is still in flight. It also detects the one dependency that forwarding cannot cover in time. That case is a load in execute whose destination is read by the instruction right behind it in decode.

All outputs are combinational functions of the present contents of the pipeline registers. The operand selects are therefore re-derived in every cycle and remain correct when instructions stall and then resume. When a load-use conflict is seen, the unit raises a hold for the program counter and the fetch/decode register. In the same cycle it raises a bubble request for the decode/execute register. Later stages keep moving, so one empty slot opens behind the load. The surrounding pipeline turns the bubble request into an entry whose write and memory enables are all clear. After that single cycle, the loaded value reaches the writeback register and is bypassed from there. Register 0 is hard-wired and takes no part in any of this.

Top module: `raw_hazard_unit`

## Requirements
- R1: Each source `i` has a 2-bit select at `fwdSel[2i+1:2i]`. The encoding is 00 = register file, 01 = result held in the memory-stage register (execute/memory), and 10 = result held in the writeback-stage register (memory/writeback). Code 11 never appears.
- R2: When the memory-stage instruction has `memWe`=1 and `memDst` equals a non-zero execute source, that source's select is 01.
- R3: When only the writeback-stage instruction matches a non-zero execute source with `wbWe`=1, that source's select is 10.
- R4: When both the memory-stage and writeback-stage instructions match the same source, the newer one wins and the select is 01.
- R5: Register 0 never selects a bypass path and never causes a stall, whatever the stage contents.
- R6: A stage whose write-enable is 0 never matches. It produces no bypass and no stall, even when its destination equals a source.
- R7: A load in execute (`exeLoad`=1, `exeWe`=1) whose non-zero destination equals either decode source drives `stallFront`=1 and `bubbleEx`=1 in the same cycle.
- R8: A non-load writer in execute matching a decode source causes no stall.
- R9: A load that has moved on to the memory or writeback stage causes no stall. After the single bubble, the dependent instruction in execute selects 10 for the loaded register.
- R10: Selects follow the current stage contents only. The same execute source changes its select as producers move between stages. Decode sources have no effect on the selects.
- R11: The two sources are resolved independently and may pick different paths in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decSrc | input | NSRC*AW | Source register numbers of the instruction in decode, source i at [AW*i +: AW] |
| exeSrc | input | NSRC*AW | Source register numbers of the instruction in execute |
| exeDst | input | AW | Destination of the instruction in execute |
| exeWe | input | 1 | Execute-stage instruction writes a register |
| exeLoad | input | 1 | Execute-stage instruction is a load |
| memDst | input | AW | Destination of the instruction in the memory stage |
| memWe | input | 1 | Memory-stage instruction writes a register |
| wbDst | input | AW | Destination of the instruction in writeback |
| wbWe | input | 1 | Writeback-stage instruction writes a register |
| fwdSel | output | 2*NSRC | Per-source ALU operand select (R1 encoding) |
| stallFront | output | 1 | Hold the program counter and the fetch/decode register |
| bubbleEx | output | 1 | Load an empty entry into the decode/execute register |

## Verification
The embedded assertions check, on every evaluation, the following: select codes stay legal, register 0 never bypasses, a 01 or 10 select always has an enabled producer with a matching destination (with no newer match for 10), stages with cleared write-enables produce no bypass, and a hold is always paired with a bubble and backed by a writing load in execute. The bench scenarios alone show that the right path is chosen when a bypass is needed, that a load-use pair stalls for exactly one cycle, and that the loaded value is then picked up from writeback. They also show that selects track producers as those producers advance while the decode instruction is held.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source for one ALU input mux
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwdSel_e;

  // Strobes passed from the comparator datapath to the control for one source slot
  typedef struct packed {
    logic fromMem;   // execute source hits the memory-stage writer
    logic fromWb;    // execute source hits the writeback-stage writer
    logic loadUse;   // decode source hits a load sitting in execute
  } hitStrb_t;

endpackage

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC*AW-1:0]          decSrc,
  input  logic [NSRC*AW-1:0]          exeSrc,
  input  logic [AW-1:0]               exeDst,
  input  logic                        exeWe,
  input  logic                        exeLoad,
  input  logic [AW-1:0]               memDst,
  input  logic                        memWe,
  input  logic [AW-1:0]               wbDst,
  input  logic                        wbWe,
  output hzd_pkg::hitStrb_t [NSRC-1:0] hits
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  // A producer counts only when it writes, and register 0 is never a dependency
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      logic [AW-1:0]     decReg;
      logic [AW-1:0]     exeReg;
      hzd_pkg::hitStrb_t slotHit;

      assign decReg = decSrc[gi*AW +: AW];
      assign exeReg = exeSrc[gi*AW +: AW];

      always_comb begin
        slotHit.fromMem = memWe && (memDst == exeReg) && (exeReg != ZERO_REG);
        slotHit.fromWb  = wbWe  && (wbDst  == exeReg) && (exeReg != ZERO_REG);
        slotHit.loadUse = exeWe && exeLoad && (exeDst == decReg) && (decReg != ZERO_REG);
      end

      assign hits[gi] = slotHit;
    end
  endgenerate

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
  parameter int NSRC = 2
) (
  input  hzd_pkg::hitStrb_t [NSRC-1:0] hits,
  output logic [2*NSRC-1:0]            fwdSel,
  output logic                         holdFront,
  output logic                         insertBubble
);

  import hzd_pkg::*;

  // Newest producer wins; the register file is the fallback
  always_comb begin
    fwdSel    = '0;
    holdFront = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (hits[i].fromMem)     fwdSel[2*i +: 2] = SEL_MEM;
      else if (hits[i].fromWb) fwdSel[2*i +: 2] = SEL_WB;
      else                     fwdSel[2*i +: 2] = SEL_RF;
      holdFront = holdFront | hits[i].loadUse;
    end
  end

  // One empty slot enters execute while the front end waits
  always_comb insertBubble = holdFront;

endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC*AW-1:0] decSrc,
  input  logic [NSRC*AW-1:0] exeSrc,
  input  logic [AW-1:0]      exeDst,
  input  logic               exeWe,
  input  logic               exeLoad,
  input  logic [AW-1:0]      memDst,
  input  logic               memWe,
  input  logic [AW-1:0]      wbDst,
  input  logic               wbWe,
  output logic [2*NSRC-1:0]  fwdSel,
  output logic               stallFront,
  output logic               bubbleEx
);

  hzd_pkg::hitStrb_t [NSRC-1:0] hits;

  hzd_cmp #(.AW(AW), .NSRC(NSRC)) cmp_i (
    .decSrc  (decSrc),
    .exeSrc  (exeSrc),
    .exeDst  (exeDst),
    .exeWe   (exeWe),
    .exeLoad (exeLoad),
    .memDst  (memDst),
    .memWe   (memWe),
    .wbDst   (wbDst),
    .wbWe    (wbWe),
    .hits    (hits)
  );

  hzd_ctrl #(.NSRC(NSRC)) ctrl_i (
    .hits         (hits),
    .fwdSel       (fwdSel),
    .holdFront    (stallFront),
    .insertBubble (bubbleEx)
  );

  // Per-source checks on the outputs against the stage contents
  genvar ga;
  generate
    for (ga = 0; ga < NSRC; ga++) begin : g_chk
      logic [AW-1:0] srcReg;
      logic [1:0]    selNow;
      assign srcReg = exeSrc[ga*AW +: AW];
      assign selNow = fwdSel[2*ga +: 2];

      always_comb begin
        p_sel_legal_r1: assert (selNow != 2'b11)
          else $error("select code 11 on source %0d", ga);
        if (srcReg == '0) begin
          p_zero_no_fwd_r5: assert (selNow == 2'b00)
            else $error("register 0 bypassed on source %0d", ga);
        end
        if (!memWe && !wbWe) begin
          p_no_we_no_fwd_r6: assert (selNow == 2'b00)
            else $error("bypass without any writer on source %0d", ga);
        end
        if (selNow == 2'b01) begin
          p_mem_sel_backed_r2: assert (memWe && memDst == srcReg)
            else $error("memory-stage select without a matching writer");
        end
        if (selNow == 2'b10) begin
          p_wb_sel_newest_r4: assert (wbWe && wbDst == srcReg && !(memWe && memDst == srcReg))
            else $error("writeback select while not the newest match");
        end
      end
    end
  endgenerate

  always_comb begin
    p_bubble_with_hold_r7: assert (bubbleEx == stallFront)
      else $error("bubble and hold disagree");
    if (stallFront) begin
      p_hold_needs_load_r8: assert (exeLoad && exeWe && exeDst != '0)
        else $error("hold raised without a writing load in execute");
    end
  end

endmodule

// File: tb/raw_hazard_unit_tb.sv
module raw_hazard_unit_tb_top;

  localparam int AW   = 5;
  localparam int NSRC = 2;

  typedef struct packed {
    logic [4:0] d0, d1, e0, e1, eDst;
    logic       eWe, eLd;
    logic [4:0] mDst;
    logic       mWe;
    logic [4:0] wDst;
    logic       wWe;
    logic [1:0] s0, s1;
    logic       st;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  //                d0    d1    e0    e1    eDst eWe eLd mDst  mWe wDst  wWe s0     s1     st  req
  localparam vec_t VECS [NV] = '{
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b0,2'b00,2'b00,1'b0,4'd1},  // R1 idle
    '{5'd0, 5'd0, 5'd3, 5'd0, 5'd0, 1'b0,1'b0,5'd3, 1'b1,5'd0, 1'b0,2'b01,2'b00,1'b0,4'd2},  // R2
    '{5'd0, 5'd0, 5'd0, 5'd4, 5'd0, 1'b0,1'b0,5'd0, 1'b0,5'd4, 1'b1,2'b00,2'b10,1'b0,4'd3},  // R3
    '{5'd0, 5'd0, 5'd7, 5'd7, 5'd0, 1'b0,1'b0,5'd7, 1'b1,5'd7, 1'b1,2'b01,2'b01,1'b0,4'd4},  // R4
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1,1'b1,5'd0, 1'b1,5'd0, 1'b1,2'b00,2'b00,1'b0,4'd5},  // R5
    '{5'd6, 5'd0, 5'd5, 5'd0, 5'd6, 1'b0,1'b1,5'd5, 1'b0,5'd5, 1'b0,2'b00,2'b00,1'b0,4'd6},  // R6
    '{5'd8, 5'd1, 5'd0, 5'd0, 5'd8, 1'b1,1'b1,5'd0, 1'b0,5'd0, 1'b0,2'b00,2'b00,1'b1,4'd7},  // R7 source 0
    '{5'd2, 5'd9, 5'd0, 5'd0, 5'd9, 1'b1,1'b1,5'd0, 1'b0,5'd0, 1'b0,2'b00,2'b00,1'b1,4'd7},  // R7 source 1
    '{5'd10,5'd0, 5'd0, 5'd0, 5'd10,1'b1,1'b0,5'd0, 1'b0,5'd0, 1'b0,2'b00,2'b00,1'b0,4'd8},  // R8
    '{5'd11,5'd11,5'd0, 5'd0, 5'd0, 1'b0,1'b0,5'd11,1'b1,5'd11,1'b1,2'b00,2'b00,1'b0,4'd9},  // R9
    '{5'd0, 5'd0, 5'd12,5'd13,5'd0, 1'b0,1'b0,5'd13,1'b1,5'd12,1'b1,2'b10,2'b01,1'b0,4'd11}, // R11
    '{5'd0, 5'd0, 5'd14,5'd0, 5'd0, 1'b0,1'b0,5'd14,1'b1,5'd15,1'b1,2'b01,2'b00,1'b0,4'd2}   // R2 other writer in wb
  };

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NSRC*AW-1:0]   decSrc = '0;
  logic [NSRC*AW-1:0]   exeSrc = '0;
  logic [AW-1:0]        exeDst = '0;
  logic                 exeWe = 1'b0;
  logic                 exeLoad = 1'b0;
  logic [AW-1:0]        memDst = '0;
  logic                 memWe = 1'b0;
  logic [AW-1:0]        wbDst = '0;
  logic                 wbWe = 1'b0;
  logic [2*NSRC-1:0]    fwdSel;
  logic                 stallFront;
  logic                 bubbleEx;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;  // 8 ns period

  raw_hazard_unit #(.AW(AW), .NSRC(NSRC)) dut_i (
    .decSrc     (decSrc),
    .exeSrc     (exeSrc),
    .exeDst     (exeDst),
    .exeWe      (exeWe),
    .exeLoad    (exeLoad),
    .memDst     (memDst),
    .memWe      (memWe),
    .wbDst      (wbDst),
    .wbWe       (wbWe),
    .fwdSel     (fwdSel),
    .stallFront (stallFront),
    .bubbleEx   (bubbleEx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setStages(input logic [4:0] d0, d1, e0, e1, eDst, input logic eWe, eLd,
                           input logic [4:0] mDst, input logic mWe, input logic [4:0] wDst, input logic wWe);
    decSrc  = {d1, d0};
    exeSrc  = {e1, e0};
    exeDst  = eDst;
    exeWe   = eWe;
    exeLoad = eLd;
    memDst  = mDst;
    memWe   = mWe;
    wbDst   = wDst;
    wbWe    = wWe;
  endtask

  task automatic chkAll(input string req, input logic [1:0] s0, s1, input logic st);
    chk(req, "sel0", 32'(fwdSel[1:0]), 32'(s0));
    chk(req, "sel1", 32'(fwdSel[3:2]), 32'(s1));
    chk(req, "stall", 32'(stallFront), 32'(st));
    chk(req, "bubble", 32'(bubbleEx), 32'(st));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // Reset state: idle pipeline gives register-file selects and no stall (R1)
    @(negedge clk);
    #1;
    chkAll("R1", 2'b00, 2'b00, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      setStages(VECS[i].d0, VECS[i].d1, VECS[i].e0, VECS[i].e1, VECS[i].eDst, VECS[i].eWe,
                VECS[i].eLd, VECS[i].mDst, VECS[i].mWe, VECS[i].wDst, VECS[i].wWe);
      #1;
      chkAll($sformatf("R%0d", VECS[i].req), VECS[i].s0, VECS[i].s1, VECS[i].st);
    end

    // Load-use walk: load r8 in execute, dependent reads r8 in decode (R7)
    @(negedge clk);
    setStages(5'd8, 5'd0, 5'd1, 5'd2, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    #1;
    chkAll("R7", 2'b00, 2'b00, 1'b1);
    // Bubble in execute, load now in memory stage, decode held: no further stall (R9)
    @(negedge clk);
    setStages(5'd8, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 5'd1, 1'b1);
    #1;
    chkAll("R9", 2'b00, 2'b00, 1'b0);
    // Dependent in execute, load in writeback, bubble in memory: bypass from writeback (R9)
    @(negedge clk);
    setStages(5'd3, 5'd4, 5'd8, 5'd0, 5'd20, 1'b1, 1'b0, 5'd0, 1'b0, 5'd8, 1'b1);
    #1;
    chkAll("R9", 2'b10, 2'b00, 1'b0);

    // R10: same execute source, producer advances from memory to writeback
    @(negedge clk);
    setStages(5'd0, 5'd0, 5'd17, 5'd0, 5'd0, 1'b0, 1'b0, 5'd17, 1'b1, 5'd0, 1'b0);
    #1;
    chk("R10", "sel0 mem", 32'(fwdSel[1:0]), 32'h1);
    @(negedge clk);
    setStages(5'd0, 5'd0, 5'd17, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd17, 1'b1);
    #1;
    chk("R10", "sel0 wb", 32'(fwdSel[1:0]), 32'h2);
    // R10: decode sources do not influence selects
    @(negedge clk);
    setStages(5'd17, 5'd17, 5'd17, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd17, 1'b1);
    #1;
    chk("R10", "sel0 decode-indep", 32'(fwdSel[1:0]), 32'h2);
    chk("R10", "sel1 decode-indep", 32'(fwdSel[3:2]), 32'h0);

    // R6: load in execute with write-enable clear never stalls
    @(negedge clk);
    setStages(5'd21, 5'd21, 5'd0, 5'd0, 5'd21, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    #1;
    chk("R6", "stall", 32'(stallFront), 32'h0);

    // R5: load to register 0 with decode reading register 0
    @(negedge clk);
    setStages(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1);
    #1;
    chkAll("R5", 2'b00, 2'b00, 1'b0);

    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule